// File: doc/BRIEF.md
# Page-Translated DMA Channel Engine

This block runs four DMA channels whose logical addresses pass through a page table kept in system memory. Software sets up each channel through a 32-bit register bus: a control word that enables the channel and fixes its direction, a remaining byte count and a logical address. Software also sets a table base and a table limit that all channels share.

A peripheral then asks for a transfer: it names a channel, the direction and how many bytes it wants moved. The engine cuts the transfer into pieces that never cross a 4096-byte page. For each piece it checks the page number against the table limit, reads the 8-byte table entry, and issues one data access at the physical frame plus the offset within the page. The count and logical address advance after each piece. The result of the request is left in three sticky flags in the control word: terminal count, memory error and address error. The flags are cleared when the next request on that channel is accepted.

The memory side is a single valid/ack port that carries both table reads and data accesses. Requests are served one at a time.

Top module: `pgdma_engine`

## Requirements
- R1: After reset, the table base, the table limit and every channel register read zero, `req_ready` is high and `mem_valid` is low.
- R2: The table base is at offset 0x000 and the table limit at 0x008. Channel c occupies 0x100 + 32*c: the control word at +0x08, the count at +0x10 and the logical address at +0x18. Offset +0x00 of a channel reads zero. Every register reads back the full 32 bits that were last written.
- R3: Control bits: bit 0 enables the channel, bit 1 = 1 selects memory-to-device, bit 8 is terminal count, bit 9 is memory error and bit 10 is address error. Accepting a request clears bits 8 to 10 of that channel before anything else happens.
- R4: If the channel is disabled, or `req_to_dev` differs from control bit 1, bit 9 is set, no memory access is made, and the count and address are left unchanged.
- R5: The requested length is cut down to the channel's count. If the count is already zero, bit 8 is set and no memory access is made.
- R6: Each data access has length min(remaining length, 4096 - (logical address mod 4096)) and is nonzero. `mem_valid` and the access fields hold steady until `mem_ack`.
- R7: Before each data access there is one table read (`mem_kind`=0, `mem_len`=8) at (base + (logical address / 4096) * 8) with bit 31 cleared. The first data word returned is the physical frame address.
- R8: If the page index is not less than limit / 8, bit 9 is set and the transfer stops before that page. Earlier pieces remain counted.
- R9: A data access (`mem_kind`=1) addresses frame + (logical address mod 4096). `mem_we`=1 when the channel moves data from the device to memory (bit 1 = 0).
- R10: After each data access, the count drops by the piece length and the logical address rises by it. When the count reaches zero, bit 8 is set and the request ends.
- R11: `req_ready` is low from acceptance until the request ends. `done` pulses for exactly one cycle at the end. No memory access is made while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 2 | Channel of the request |
| req_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| req_len | input | 16 | Requested byte count |
| req_ready | output | 1 | Engine idle, request accepted when high |
| done | output | 1 | One-cycle pulse at the end of a request |
| mem_valid | output | 1 | Memory access pending |
| mem_kind | output | 1 | 0 = table read, 1 = data access |
| mem_we | output | 1 | Data access writes memory |
| mem_addr | output | 32 | Physical byte address |
| mem_len | output | 13 | Access length in bytes |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Table entry frame word, valid with `mem_ack` |

## Verification
A wrong walker state shows up at the memory port on the very next access. It appears as an access of the wrong kind, an address that is off by a page or not masked, or a piece length that crosses a page. The scoreboard catches it at that handshake. A wrong count, address or flag update leaves no trace on the memory port until the request ends. It is seen when the three channel registers are read right after `done`, or one request later as an extra or missing piece. A missed flag clear shows up as a stale bit in the control word read after the next request.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;

  localparam int PAGE_BYTES  = 4096;
  localparam int ENTRY_BYTES = 8;

  // control word bit positions (software-visible encoding)
  localparam int CTL_EN    = 0;
  localparam int CTL_TODEV = 1;
  localparam int CTL_TC    = 8;
  localparam int CTL_MERR  = 9;
  localparam int CTL_AERR  = 10;

  localparam logic [31:0] FLAG_MASK = 32'h0000_0700;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_PAGE, ST_FETCH, ST_DATA, ST_DONE
  } walk_state_t;

  // bytes moved in one piece: never past the next page boundary
  function automatic logic [12:0] piece_len(input logic [31:0] remain,
                                            input logic [31:0] laddr);
    logic [12:0] to_edge;
    to_edge = 13'd4096 - {1'b0, laddr[11:0]};
    if (remain < {19'd0, to_edge}) return remain[12:0];
    return to_edge;
  endfunction

  // location of the translation entry for a logical address
  function automatic logic [31:0] entry_loc(input logic [31:0] base,
                                            input logic [31:0] laddr);
    logic [31:0] sum;
    sum = base + {9'd0, laddr[31:12], 3'b000};
    return sum & 32'h7FFF_FFFF;
  endfunction

  // page index inside the table limit
  function automatic logic page_in_table(input logic [31:0] laddr,
                                         input logic [31:0] limit);
    return {12'd0, laddr[31:12]} < {3'd0, limit[31:3]};
  endfunction

endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs
  import pgdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CHW-1:0]    eng_ch,
  input  logic              eng_ctl_we,
  input  logic [31:0]       eng_ctl,
  input  logic              eng_cnt_we,
  input  logic [31:0]       eng_cnt,
  input  logic              eng_lad_we,
  input  logic [31:0]       eng_lad,
  output logic [31:0]       tbl_base,
  output logic [31:0]       tbl_limit,
  output logic [31:0]       ch_ctl [NCH],
  output logic [31:0]       ch_cnt [NCH],
  output logic [31:0]       ch_lad [NCH]
);

  // decode: 0x000 base, 0x008 limit, 0x100 + 32*ch + 8*k channel words
  logic       hit_base, hit_limit, hit_chan;
  logic [2:0] sel_ch;
  logic [1:0] sel_word;

  assign hit_base  = (bus_addr[AW-1:2] == '0);
  assign hit_limit = (bus_addr[AW-1:2] == (AW-2)'(2));
  assign hit_chan  = (bus_addr[AW-1:8] == (AW-8)'(1));
  assign sel_ch    = bus_addr[7:5];
  assign sel_word  = bus_addr[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base  <= '0;
      tbl_limit <= '0;
    end else if (bus_we) begin
      if (hit_base)  tbl_base  <= bus_wdata;
      if (hit_limit) tbl_limit <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic bus_sel, eng_sel;
    assign bus_sel = bus_we && hit_chan && (sel_ch == 3'(g));
    assign eng_sel = (eng_ch == CHW'(g));

    // engine updates win over a bus write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctl[g] <= '0;
        ch_cnt[g] <= '0;
        ch_lad[g] <= '0;
      end else begin
        if (eng_sel && eng_ctl_we)              ch_ctl[g] <= eng_ctl;
        else if (bus_sel && sel_word == 2'd1)   ch_ctl[g] <= bus_wdata;
        if (eng_sel && eng_cnt_we)              ch_cnt[g] <= eng_cnt;
        else if (bus_sel && sel_word == 2'd2)   ch_cnt[g] <= bus_wdata;
        if (eng_sel && eng_lad_we)              ch_lad[g] <= eng_lad;
        else if (bus_sel && sel_word == 2'd3)   ch_lad[g] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_base)  bus_rdata = tbl_base;
    if (hit_limit) bus_rdata = tbl_limit;
    if (hit_chan) begin
      for (int g = 0; g < NCH; g++) begin
        if (sel_ch == 3'(g)) begin
          case (sel_word)
            2'd1:    bus_rdata = ch_ctl[g];
            2'd2:    bus_rdata = ch_cnt[g];
            2'd3:    bus_rdata = ch_lad[g];
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pgdma_walker.sv
module pgdma_walker
  import pgdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int LEN_W = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CHW-1:0]    req_chan,
  input  logic              req_to_dev,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              done,
  input  logic [31:0]       tbl_base,
  input  logic [31:0]       tbl_limit,
  input  logic [31:0]       ch_ctl [NCH],
  input  logic [31:0]       ch_cnt [NCH],
  input  logic [31:0]       ch_lad [NCH],
  output logic [CHW-1:0]    eng_ch,
  output logic              eng_ctl_we,
  output logic [31:0]       eng_ctl,
  output logic              eng_cnt_we,
  output logic [31:0]       eng_cnt,
  output logic              eng_lad_we,
  output logic [31:0]       eng_lad,
  output logic              mem_valid,
  output logic              mem_kind,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [12:0]       mem_len,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  walk_state_t   st;
  logic [CHW-1:0] cur_ch;
  logic          cur_todev;
  logic [31:0]   remain;
  logic [31:0]   frame;

  // named internal events
  logic        start_evt, reject_evt, limit_evt, piece_evt;
  logic [31:0] cctl, ccnt, clad;
  logic [12:0] piece;
  logic [31:0] cnt_after;

  assign cctl      = ch_ctl[cur_ch];
  assign ccnt      = ch_cnt[cur_ch];
  assign clad      = ch_lad[cur_ch];
  assign piece     = piece_len(remain, clad);
  assign cnt_after = ccnt - {19'd0, piece};

  assign start_evt  = (st == ST_IDLE) && req_valid;
  assign reject_evt = (st == ST_CHECK) &&
                      (!cctl[CTL_EN] || (cctl[CTL_TODEV] != cur_todev));
  assign limit_evt  = (st == ST_PAGE) && !page_in_table(clad, tbl_limit);
  assign piece_evt  = (st == ST_DATA) && mem_ack;

  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign eng_ch    = (st == ST_IDLE) ? req_chan : cur_ch;

  always_comb begin
    mem_valid = 1'b0;
    mem_kind  = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_len   = '0;
    if (st == ST_FETCH) begin
      mem_valid = 1'b1;
      mem_addr  = entry_loc(tbl_base, clad);
      mem_len   = 13'(ENTRY_BYTES);
    end else if (st == ST_DATA) begin
      mem_valid = 1'b1;
      mem_kind  = 1'b1;
      mem_we    = !cur_todev;
      mem_addr  = frame + {20'd0, clad[11:0]};
      mem_len   = piece;
    end
  end

  always_comb begin
    eng_ctl_we = 1'b0;
    eng_ctl    = cctl;
    eng_cnt_we = 1'b0;
    eng_cnt    = cnt_after;
    eng_lad_we = 1'b0;
    eng_lad    = clad + {19'd0, piece};
    if (start_evt) begin
      eng_ctl_we = 1'b1;
      eng_ctl    = ch_ctl[req_chan] & ~FLAG_MASK;
    end else if (reject_evt || limit_evt) begin
      eng_ctl_we = 1'b1;
      eng_ctl    = cctl | (32'd1 << CTL_MERR);
    end else if (st == ST_CHECK && ccnt == '0) begin
      eng_ctl_we = 1'b1;
      eng_ctl    = cctl | (32'd1 << CTL_TC);
    end else if (piece_evt) begin
      eng_cnt_we = 1'b1;
      eng_lad_we = 1'b1;
      if (cnt_after == '0) begin
        eng_ctl_we = 1'b1;
        eng_ctl    = cctl | (32'd1 << CTL_TC);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_ch    <= '0;
      cur_todev <= 1'b0;
      remain    <= '0;
      frame     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          cur_ch    <= req_chan;
          cur_todev <= req_to_dev;
          remain    <= {{(32-LEN_W){1'b0}}, req_len};
          st        <= ST_CHECK;
        end
        ST_CHECK: begin
          if (reject_evt || ccnt == '0) st <= ST_DONE;
          else begin
            if (ccnt < remain) remain <= ccnt;
            st <= (remain == '0) ? ST_DONE : ST_PAGE;
          end
        end
        ST_PAGE:  st <= limit_evt ? ST_DONE : ST_FETCH;
        ST_FETCH: if (mem_ack) begin
          frame <= mem_rdata;
          st    <= ST_DATA;
        end
        ST_DATA: if (mem_ack) begin
          remain <= remain - {19'd0, piece};
          if (remain == {19'd0, piece} || cnt_after == '0) st <= ST_DONE;
          else st <= ST_PAGE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: flags of the accepted channel are clear one cycle later
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (ch_ctl[cur_ch][10:8] == 3'b000));

  // R6: access fields hold while waiting for ack
  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)
                                 && $stable(mem_kind)));

  // R6: a data piece stays inside one page and is nonempty
  p_piece_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_kind) |-> (mem_len != 13'd0 &&
      ({1'b0, clad[11:0]} + mem_len) <= 13'd4096));

  // R7: table reads never carry bit 31
  p_fetch_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_kind) |-> (!mem_addr[31] && mem_len == 13'd8));

  // R10: count falls and address rises by the piece just moved
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    piece_evt |=> (ch_cnt[cur_ch] == $past(ccnt) - {19'd0, $past(piece)} &&
                   ch_lad[cur_ch] == $past(clad) + {19'd0, $past(piece)}));

  // R4: a rejected request moves nothing
  p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (done && !mem_valid));

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
  import pgdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int LEN_W = 16,
  parameter int AW    = 10,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [CHW-1:0]    req_chan,
  input  logic              req_to_dev,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              done,
  output logic              mem_valid,
  output logic              mem_kind,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [12:0]       mem_len,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  logic [31:0]    tbl_base, tbl_limit;
  logic [31:0]    ch_ctl [NCH];
  logic [31:0]    ch_cnt [NCH];
  logic [31:0]    ch_lad [NCH];
  logic [CHW-1:0] eng_ch;
  logic           eng_ctl_we, eng_cnt_we, eng_lad_we;
  logic [31:0]    eng_ctl, eng_cnt, eng_lad;

  pgdma_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (reg_we),
    .bus_addr  (reg_addr),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .eng_ch    (eng_ch),
    .eng_ctl_we(eng_ctl_we),
    .eng_ctl   (eng_ctl),
    .eng_cnt_we(eng_cnt_we),
    .eng_cnt   (eng_cnt),
    .eng_lad_we(eng_lad_we),
    .eng_lad   (eng_lad),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .ch_ctl    (ch_ctl),
    .ch_cnt    (ch_cnt),
    .ch_lad    (ch_lad)
  );

  pgdma_walker #(.NCH(NCH), .LEN_W(LEN_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .req_to_dev(req_to_dev),
    .req_len   (req_len),
    .req_ready (req_ready),
    .done      (done),
    .tbl_base  (tbl_base),
    .tbl_limit (tbl_limit),
    .ch_ctl    (ch_ctl),
    .ch_cnt    (ch_cnt),
    .ch_lad    (ch_lad),
    .eng_ch    (eng_ch),
    .eng_ctl_we(eng_ctl_we),
    .eng_ctl   (eng_ctl),
    .eng_cnt_we(eng_cnt_we),
    .eng_cnt   (eng_cnt),
    .eng_lad_we(eng_lad_we),
    .eng_lad   (eng_lad),
    .mem_valid (mem_valid),
    .mem_kind  (mem_kind),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  // R11: an idle engine makes no memory access
  p_idle_no_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  // R8: a limit fault ends the request with no further access
  p_limit_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    u_walker.limit_evt |=> (done && !mem_valid));

endmodule

// File: tb/test_pgdma_engine.sv
module test_pgdma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic        req_to_dev = 1'b0;
  logic [15:0] req_len = '0;
  logic        req_ready, done;
  logic        mem_valid, mem_kind, mem_we;
  logic [31:0] mem_addr;
  logic [12:0] mem_len;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pgdma_engine i_pgdma_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_chan(req_chan), .req_to_dev(req_to_dev), .req_len(req_len),
    .req_ready(req_ready), .done(done),
    .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct {
    bit          kind;
    bit          we;
    logic [31:0] addr;
    logic [12:0] len;
    string       tag;
  } op_t;

  op_t exp_q[$];

  // shadow of what software wrote
  logic [31:0] sh_base = 0, sh_limit = 0;
  logic [31:0] sh_ctl[4], sh_cnt[4], sh_lad[4];

  function automatic logic [31:0] frame_of(input logic [31:0] ea);
    return 32'h2000_0000 + {3'd0, ea[19:3], 12'h000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory model and monitor: log the access when it is acknowledged
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_valid && rst_n) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_kind ? 32'hDEAD_BEEF : frame_of(mem_addr);
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4/R5/R8 unexpected access: actual kind %0d addr 0x%08h len %0d expected none",
                 mem_kind, mem_addr, mem_len);
      end else begin
        op_t e;
        e = exp_q.pop_front();
        if (mem_kind !== e.kind || mem_addr !== e.addr || mem_len !== e.len ||
            (e.kind && mem_we !== e.we)) begin
          n_bad++;
          $display("FAIL %s: actual kind %0d we %0d addr 0x%08h len %0d expected kind %0d we %0d addr 0x%08h len %0d",
                   e.tag, mem_kind, mem_we, mem_addr, mem_len, e.kind, e.we, e.addr, e.len);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup_ch(input int ch, input logic [31:0] c, input logic [31:0] n,
                          input logic [31:0] l);
    wr(10'(32'h100 + 32*ch + 8), c);  sh_ctl[ch] = c;
    wr(10'(32'h100 + 32*ch + 16), n); sh_cnt[ch] = n;
    wr(10'(32'h100 + 32*ch + 24), l); sh_lad[ch] = l;
  endtask

  // driver: predict, push expected accesses, run, compare final registers
  task automatic run_req(input int ch, input bit todev, input logic [15:0] len, input string tag);
    logic [31:0] ctl, cnt, lad, remain, ea, got;
    logic [12:0] pc;
    int          wait_n;
    ctl = sh_ctl[ch] & ~32'h700;
    cnt = sh_cnt[ch];
    lad = sh_lad[ch];
    if (!ctl[0] || (todev != ctl[1])) ctl |= 32'h200;
    else if (cnt == 0) ctl |= 32'h100;
    else begin
      remain = (len < cnt) ? {16'd0, len} : cnt;
      while (remain != 0) begin
        if ((lad >> 12) >= (sh_limit >> 3)) begin ctl |= 32'h200; break; end
        ea = (sh_base + ((lad >> 12) << 3)) & 32'h7FFF_FFFF;
        exp_q.push_back('{1'b0, 1'b0, ea, 13'd8, {tag, " R7 table read"}});
        pc = (remain < 4096 - (lad % 4096)) ? remain[12:0] : 13'(4096 - (lad % 4096));
        exp_q.push_back('{1'b1, !todev, frame_of(ea) + (lad % 4096), pc,
                          {tag, " R6/R9 data piece"}});
        cnt -= {19'd0, pc}; lad += {19'd0, pc}; remain -= {19'd0, pc};
        if (cnt == 0) begin ctl |= 32'h100; break; end
      end
    end
    @(negedge clk);
    req_chan = 2'(ch); req_to_dev = todev; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R11 busy after accept"}, {31'd0, req_ready}, 32'd0);
    wait_n = 0;
    while (!done && wait_n < 20000) begin @(negedge clk); wait_n++; end
    check({tag, " R11 done seen"}, {31'd0, done}, 32'd1);
    @(negedge clk);
    check({tag, " R11 done one cycle"}, {31'd0, done}, 32'd0);
    check({tag, " missing accesses"}, exp_q.size(), 0);
    exp_q.delete();
    rd(10'(32'h100 + 32*ch + 8), got);  check({tag, " R3/R10 control"}, got, ctl);
    rd(10'(32'h100 + 32*ch + 16), got); check({tag, " R10 count"}, got, cnt);
    rd(10'(32'h100 + 32*ch + 24), got); check({tag, " R10 address"}, got, lad);
    sh_ctl[ch] = ctl; sh_cnt[ch] = cnt; sh_lad[ch] = lad;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin sh_ctl[i] = 0; sh_cnt[i] = 0; sh_lad[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    rd(10'h000, v); check("R1 base", v, 0);
    rd(10'h008, v); check("R1 limit", v, 0);
    rst_n = 1'b1;
    rd(10'h108, v); check("R1 ctl0", v, 0);
    rd(10'h170, v); check("R1 cnt3", v, 0);
    rd(10'h178, v); check("R1 lad3", v, 0);

    // R2: register map and read-back
    setup_ch(2, 32'hCAFE_0702, 32'h1234_5678, 32'h9ABC_DEF0);
    rd(10'h148, v); check("R2 ctl2", v, 32'hCAFE_0702);
    rd(10'h150, v); check("R2 cnt2", v, 32'h1234_5678);
    rd(10'h158, v); check("R2 lad2", v, 32'h9ABC_DEF0);
    rd(10'h140, v); check("R2 word0 zero", v, 0);
    wr(10'h000, 32'h8000_1000); sh_base = 32'h8000_1000;
    wr(10'h008, 32'h0000_0100); sh_limit = 32'h0000_0100;
    rd(10'h000, v); check("R2 base", v, 32'h8000_1000);
    rd(10'h008, v); check("R2 limit", v, 32'h0000_0100);

    // R6 R7 R9 R10: device to memory across two page edges
    setup_ch(0, 32'h1, 32'h3000, 32'h0000_0F00);
    run_req(0, 1'b0, 16'h1800, "R6 split");
    // ends exactly on a page edge
    run_req(0, 1'b0, 16'h0900, "R6 edge");
    // R5: clamp to count, memory to device, count reaches zero
    setup_ch(1, 32'h3, 32'h80, 32'h5000);
    run_req(1, 1'b1, 16'h0200, "R5 clamp");
    // R5: count already zero
    run_req(1, 1'b1, 16'h0010, "R5 zero count");
    // R3: stale flags cleared
    setup_ch(2, 32'h701, 32'h10, 32'h0);
    run_req(2, 1'b0, 16'h0004, "R3 stale flags");
    // R4: disabled channel and direction mismatch
    setup_ch(3, 32'h0, 32'h40, 32'h100);
    run_req(3, 1'b0, 16'h0010, "R4 disabled");
    run_req(0, 1'b1, 16'h0010, "R4 mismatch");
    // R8: last valid page then limit fault
    setup_ch(3, 32'h1, 32'h2000, 32'h0001_F800);
    run_req(3, 1'b0, 16'h1000, "R8 limit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule